// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes the processor state changes for taking an exception in a 32-bit core with banked status registers. A caller raises a one-cycle entry strobe together with a set of pending exception requests. The same cycle also carries the current program counter, the current status word, the live condition flags and two control bits. One of the control bits places the vector table high in memory. The other selects the compact instruction state for handlers.

The block picks the winning request by fixed priority. One clock later it presents the new status word, the status word to be saved, the bank that receives it, the return (link) address and the handler fetch address. All of these appear together with a one-cycle valid pulse. A request made while vectored-interrupt mode is enabled is refused: no state is produced, and an error pulse is raised instead.

Top module: `exc_entry`

## Requirements
- R1: After reset, all outputs are zero, including `valid_o` and `err_o`.
- R2: Request bits are indexed 0 reset, 1 undefined instruction, 2 supervisor call, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ. When several are set, the winner follows the order reset, data abort, FIQ, IRQ, prefetch abort, undefined, supervisor call. All outputs update together on the clock edge after `entry_i`, and `valid_o` is high for exactly that one cycle.
- R3: `fetch_pc_o` is the handler offset plus a base. The offsets are: reset 0x00, undefined 0x04, supervisor call 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. The base is 0xFFFF0000 when `hivec_i` is 1 and 0 otherwise.
- R4: The mode field is bits 4:0 of `new_psr_o`. Its values are: reset and supervisor call 0x13, undefined 0x1B, both aborts 0x17, IRQ 0x12, FIQ 0x11. `bank_o` encodes the same target as 0 SVC, 1 UND, 2 ABT, 3 IRQ, 4 FIQ.
- R5: `link_o` is `pc_i` plus an offset chosen by `psr_i[5]`. With bit 5 at 0 the offsets are: undefined/supervisor 4, prefetch abort/IRQ/FIQ 4, data abort 8, reset 0. With bit 5 at 1 they are: undefined/supervisor 2, prefetch abort/IRQ/FIQ 4, data abort 8, reset 0.
- R6: In `new_psr_o`, bit 7 is always set. Bit 8 is ORed with 1 for reset, both aborts, IRQ and FIQ. Bit 6 is ORed with 1 only for reset and FIQ. Otherwise bits 8 and 6 keep their value from `psr_i`.
- R7: In `new_psr_o`, bits 24, 26:25 and 15:10 are cleared. Bit 5 is set when `exc_state_i` is 1 and keeps its `psr_i` value otherwise. All other bits keep their `psr_i` values.
- R8: `saved_psr_o` is `psr_i` ORed with `flags_i` placed in bits 31:27 (N, Z, C, V, Q from high to low).
- R9: If `entry_i` arrives with any request while `vec_mode_i` is 1, then `err_o` pulses for one cycle, `valid_o` stays low, and the data outputs keep their previous values.
- R10: An `entry_i` with no request bit set produces neither `valid_o` nor `err_o`, and the data outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_i | input | 1 | Entry strobe |
| req_i | input | 7 | Pending exception requests |
| pc_i | input | 32 | Current program counter |
| psr_i | input | 32 | Current status word |
| flags_i | input | 5 | Live N, Z, C, V, Q flags |
| hivec_i | input | 1 | High vector table select |
| exc_state_i | input | 1 | Enter handlers in compact state |
| vec_mode_i | input | 1 | Vectored-interrupt mode enabled (unsupported) |
| valid_o | output | 1 | Entry result valid pulse |
| err_o | output | 1 | Refused entry pulse |
| new_psr_o | output | 32 | Status word after entry |
| saved_psr_o | output | 32 | Status word to bank |
| bank_o | output | 3 | Saved-status bank select |
| link_o | output | 32 | Return address |
| fetch_pc_o | output | 32 | Handler fetch address |

## Verification
The bench targets simultaneous requests. If the priority were wrong, a data abort arriving with an FIQ would vector to 0x1C instead of 0x10. It also exercises the compact-state link offsets, where a design that ignores `psr_i[5]` returns 4 instead of 2 for a supervisor call. Further cases are masks that must be ORed rather than overwritten (bit 6 must survive an IRQ), and the high vector base. Refused entries and empty entries are checked for leaking a valid pulse or disturbing the held outputs.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter logic [31:0] HIGH_BASE = 32'hFFFF0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        entry_i,
  input  logic [6:0]  req_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] psr_i,
  input  logic [4:0]  flags_i,
  input  logic        hivec_i,
  input  logic        exc_state_i,
  input  logic        vec_mode_i,
  output logic        valid_o,
  output logic        err_o,
  output logic [31:0] new_psr_o,
  output logic [31:0] saved_psr_o,
  output logic [2:0]  bank_o,
  output logic [31:0] link_o,
  output logic [31:0] fetch_pc_o
);
  localparam logic [4:0] M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
                         M_ABT = 5'h17, M_UND = 5'h1B;
  localparam logic [2:0] B_SVC = 3'd0, B_UND = 3'd1, B_ABT = 3'd2,
                         B_IRQ = 3'd3, B_FIQ = 3'd4;

  logic [4:0] off, mode;
  logic [2:0] bank;
  logic [3:0] lw, lc;
  logic       am, fm, hit;

  always_comb begin
    hit = |req_i;
    off = 5'h00; mode = M_SVC; bank = B_SVC; lw = 4'd0; lc = 4'd0; am = 1'b1; fm = 1'b1;
    if (req_i[0]) begin
      off = 5'h00; mode = M_SVC; bank = B_SVC; lw = 4'd0; lc = 4'd0; am = 1'b1; fm = 1'b1;
    end else if (req_i[4]) begin
      off = 5'h10; mode = M_ABT; bank = B_ABT; lw = 4'd8; lc = 4'd8; am = 1'b1; fm = 1'b0;
    end else if (req_i[6]) begin
      off = 5'h1C; mode = M_FIQ; bank = B_FIQ; lw = 4'd4; lc = 4'd4; am = 1'b1; fm = 1'b1;
    end else if (req_i[5]) begin
      off = 5'h18; mode = M_IRQ; bank = B_IRQ; lw = 4'd4; lc = 4'd4; am = 1'b1; fm = 1'b0;
    end else if (req_i[3]) begin
      off = 5'h0C; mode = M_ABT; bank = B_ABT; lw = 4'd4; lc = 4'd4; am = 1'b1; fm = 1'b0;
    end else if (req_i[1]) begin
      off = 5'h04; mode = M_UND; bank = B_UND; lw = 4'd4; lc = 4'd2; am = 1'b0; fm = 1'b0;
    end else if (req_i[2]) begin
      off = 5'h08; mode = M_SVC; bank = B_SVC; lw = 4'd4; lc = 4'd2; am = 1'b0; fm = 1'b0;
    end
  end

  logic [31:0] npsr;
  always_comb begin
    npsr = psr_i;
    npsr[4:0]   = mode;
    npsr[24]    = 1'b0;
    npsr[26:25] = 2'b00;
    npsr[15:10] = 6'b0;
    npsr[5]     = psr_i[5] | exc_state_i;
    npsr[7]     = 1'b1;
    npsr[8]     = psr_i[8] | am;
    npsr[6]     = psr_i[6] | fm;
  end

  wire [31:0] base = hivec_i ? HIGH_BASE : 32'h0;
  wire [3:0]  lofs = psr_i[5] ? lc : lw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0; err_o <= 1'b0;
      new_psr_o <= '0; saved_psr_o <= '0; bank_o <= '0; link_o <= '0; fetch_pc_o <= '0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (entry_i && hit) begin
        if (vec_mode_i) err_o <= 1'b1;
        else begin
          valid_o     <= 1'b1;
          new_psr_o   <= npsr;
          saved_psr_o <= psr_i | {flags_i, 27'b0};
          bank_o      <= bank;
          link_o      <= pc_i + {28'b0, lofs};
          fetch_pc_o  <= base + {27'b0, off};
        end
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        entry_i,
  input logic [6:0]  req_i,
  input logic        vec_mode_i,
  input logic        valid_o,
  input logic        err_o,
  input logic [31:0] new_psr_o,
  input logic [2:0]  bank_o,
  input logic [31:0] fetch_pc_o
);
  assert_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_i && |req_i && !vec_mode_i) |=> valid_o && !err_o);
  assert_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_i && |req_i && vec_mode_i) |=> err_o && !valid_o);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_i && |req_i) |=> !valid_o && !err_o && $stable(fetch_pc_o) && $stable(new_psr_o));
  assert_irqmask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> new_psr_o[7] && (bank_o != 3'd4 || new_psr_o[6]));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !new_psr_o[24] && new_psr_o[26:25] == 2'b0 && new_psr_o[15:10] == 6'b0);
  assert_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> fetch_pc_o[1:0] == 2'b0);
  assert_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> bank_o <= 3'd4);
endmodule

bind exc_entry exc_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .entry_i(entry_i), .req_i(req_i), .vec_mode_i(vec_mode_i),
  .valid_o(valid_o), .err_o(err_o), .new_psr_o(new_psr_o), .bank_o(bank_o),
  .fetch_pc_o(fetch_pc_o)
);

// File: tb/tb_exc_entry.sv
module tb_exc_entry;
  logic clk = 1'b0, rst_n = 1'b0, entry_i = 1'b0;
  logic [6:0] req_i = '0;
  logic [31:0] pc_i = '0, psr_i = '0;
  logic [4:0] flags_i = '0;
  logic hivec_i = 1'b0, exc_state_i = 1'b0, vec_mode_i = 1'b0;
  logic valid_o, err_o;
  logic [31:0] new_psr_o, saved_psr_o, link_o, fetch_pc_o;
  logic [2:0] bank_o;

  exc_entry dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] e_npsr = '0, e_spsr = '0, e_link = '0, e_pc = '0;
  logic [2:0]  e_bank = '0;
  logic        e_valid, e_err;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model(logic [6:0] rq, logic [31:0] pc, logic [31:0] psr, logic [4:0] fl,
                       logic hv, logic es, logic ve);
    int k;
    logic [4:0] off, md; logic [2:0] bk; int lw, lc; logic am, fm;
    e_valid = 0; e_err = 0;
    if (rq == 0) return;
    if (ve) begin e_err = 1; return; end
    if (rq[0]) k = 0; else if (rq[4]) k = 4; else if (rq[6]) k = 6;
    else if (rq[5]) k = 5; else if (rq[3]) k = 3; else if (rq[1]) k = 1; else k = 2;
    case (k)
      0: begin off = 5'h00; md = 5'h13; bk = 0; lw = 0; lc = 0; am = 1; fm = 1; end
      1: begin off = 5'h04; md = 5'h1B; bk = 1; lw = 4; lc = 2; am = 0; fm = 0; end
      2: begin off = 5'h08; md = 5'h13; bk = 0; lw = 4; lc = 2; am = 0; fm = 0; end
      3: begin off = 5'h0C; md = 5'h17; bk = 2; lw = 4; lc = 4; am = 1; fm = 0; end
      4: begin off = 5'h10; md = 5'h17; bk = 2; lw = 8; lc = 8; am = 1; fm = 0; end
      5: begin off = 5'h18; md = 5'h12; bk = 3; lw = 4; lc = 4; am = 1; fm = 0; end
      default: begin off = 5'h1C; md = 5'h11; bk = 4; lw = 4; lc = 4; am = 1; fm = 1; end
    endcase
    e_valid = 1;
    e_npsr = psr;
    e_npsr[4:0] = md; e_npsr[24] = 0; e_npsr[26:25] = 0; e_npsr[15:10] = 0;
    if (es) e_npsr[5] = 1;
    e_npsr[7] = 1; if (am) e_npsr[8] = 1; if (fm) e_npsr[6] = 1;
    e_spsr = psr | {fl, 27'b0};
    e_bank = bk;
    e_link = pc + (psr[5] ? lc : lw);
    e_pc = (hv ? 32'hFFFF0000 : 32'h0) + off;
  endtask

  task automatic run(logic [6:0] rq, logic [31:0] pc, logic [31:0] psr, logic [4:0] fl,
                     logic hv, logic es, logic ve, string tag);
    req_i = rq; pc_i = pc; psr_i = psr; flags_i = fl; hivec_i = hv; exc_state_i = es;
    vec_mode_i = ve; entry_i = 1;
    model(rq, pc, psr, fl, hv, es, ve);
    @(negedge clk);
    entry_i = 0; req_i = 0;
    chk({tag, " R2 valid"}, {31'b0, valid_o}, {31'b0, e_valid});
    chk({tag, " R9 err"}, {31'b0, err_o}, {31'b0, e_err});
    chk({tag, " R7 R6 R4 new_psr"}, new_psr_o, e_npsr);
    chk({tag, " R8 saved_psr"}, saved_psr_o, e_spsr);
    chk({tag, " R4 bank"}, {29'b0, bank_o}, {29'b0, e_bank});
    chk({tag, " R5 link"}, link_o, e_link);
    chk({tag, " R3 fetch_pc"}, fetch_pc_o, e_pc);
    @(negedge clk);
    chk({tag, " R2 single pulse"}, {30'b0, valid_o, err_o}, 32'b0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    chk("R1 reset state", {valid_o, err_o, bank_o, 27'b0}, 32'b0);
    chk("R1 reset psr", new_psr_o | saved_psr_o | link_o | fetch_pc_o, 32'b0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      run(7'(1 << i), 32'h0000_8000 + i * 16, 32'h0000_0010, 5'h0, 1'b0, 1'b0, 1'b0, "single");
      run(7'(1 << i), 32'h1000_0100, 32'h0700_FC30, 5'h1F, 1'b1, 1'b1, 1'b0, "R5 compact hivec");
    end
    run(7'b1010000, 32'h200, 32'h10, 5'h0, 0, 0, 0, "R2 dabt over fiq");
    run(7'b1101000, 32'h200, 32'h10, 5'h0, 0, 0, 0, "R2 fiq over irq");
    run(7'b0000110, 32'h200, 32'h30, 5'h0, 0, 0, 0, "R2 undef over svc");
    run(7'b1111111, 32'h200, 32'h10, 5'h0, 1, 0, 0, "R2 reset wins");
    run(7'b0100000, 32'h300, 32'h0000_0150, 5'h0, 0, 0, 0, "R6 fiq mask kept");
    run(7'b0000100, 32'h400, 32'h0000_0030, 5'h0, 0, 0, 0, "R5 svc compact");
    run(7'b0010000, 32'h500, 32'h10, 5'h3, 0, 0, 1, "R9 vectored refuse");
    run(7'b0000000, 32'h600, 32'h10, 5'h3, 1, 1, 0, "R10 empty entry");
    for (int n = 0; n < 400; n++) begin
      logic [6:0] rq;
      rq = 7'($urandom);
      if ($urandom % 4 == 0) rq = 7'(1 << ($urandom % 7));
      run(rq, $urandom & 32'hFFFF_FFFE, $urandom, 5'($urandom), 1'($urandom),
          1'($urandom), ($urandom % 8 == 0), "random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule